// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block is the configuration front end of a legacy Super-I/O device. The host reaches it through a two-byte I/O window. Offset 0 is the index port and offset 1 is the data port. To access a configuration register, the host writes the register number to the index port and then reads or writes the data port. The controller is locked after reset. The host opens it by writing a two-byte key sequence to the index port, and closes it again with an exit byte.

While unlocked, the controller exposes the following registers:

- fixed identification bytes;
- a logical-device selector;
- for each logical device, an activate bit and a 16-bit base address, banked behind that selector.

The activate bit and base address of the hardware-monitor logical device (number 4) are driven out continuously. Downstream address decode logic uses them to claim that device's own I/O window.

Top module: `sio_cfg_port`

## Requirements
- R1: After synchronous reset the controller is locked, `rdata` is 0x00, `hwm_active` is 0 and `hwm_base` is 0x0000.
- R2: Two consecutive index-port writes of 0x87 unlock the controller. Only index-port writes count toward this sequence.
- R3: An index-port write of 0x87 followed by any other index-port byte leaves the controller locked. The other byte also restarts the sequence, so 0x87, 0x12, 0x87 stays locked.
- R4: An index-port write of 0xAA while unlocked locks the controller again.
- R5: While locked, every read of either port returns 0xFF. Data-port writes have no effect on any register, and index-port writes do not load the index.
- R6: While unlocked, these data-port reads return fixed bytes:
  - index 0x20 returns 0x04 and index 0x21 returns 0x06 (device ID 0x0406, high byte at the lower index);
  - index 0x22 returns the revision parameter (default 0x11);
  - index 0x23 returns 0x19 and index 0x24 returns 0x34 (vendor ID 0x1934).
- R7: Index 0x07 is a read/write logical-device selector. The following registers belong to the logical device it selects:
  - index 0x30, bit 0, is that device's activate bit;
  - index 0x60 is the high byte of its base address;
  - index 0x61 is the low byte of its base address.

  Writes to a device other than number 4 leave the hardware-monitor outputs unchanged. A selector value of 8 or more reaches no device.
- R8: `hwm_active` and `hwm_base` show logical device 4's activate bit and base address. They change in the cycle after the clock edge that takes the data-port write.
- R9: While unlocked, reads of unimplemented indices return 0x00. Bits 7:1 of index 0x30 read as 0.
- R10: A read is captured on the clock edge where `rd_en` is high, and `rdata` shows it from the next cycle. `rdata` holds its value in every cycle without a read.
- R11: While unlocked, a read of the index port returns the last index written. An index-port write while unlocked loads the index, except for the exit byte 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe, one cycle per byte |
| rd_en | input | 1 | Host byte read strobe, one cycle per byte |
| port_sel | input | 1 | 0 selects the index port, 1 the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| hwm_active | output | 1 | Activate bit of logical device 4 |
| hwm_base | output | 16 | Base address of logical device 4 |

## Verification
Results appear at different delays after the host access:

- Lock state changes with the edge that takes an index write, so the very next access already sees the new state.
- Read data appears one cycle after the read strobe.
- The hardware-monitor outputs change one cycle after the data write.

The bench applies every host byte at a falling edge. It compares the design with a behavioural model at the next falling edge, which is half a cycle after the edge where both update. Each explicit check therefore samples `rdata` one full cycle after the read strobe, and samples `hwm_active` or `hwm_base` one full cycle after the write strobe.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

    localparam logic [7:0] IDX_LDSEL   = 8'h07;
    localparam logic [7:0] IDX_DEV_HI  = 8'h20;
    localparam logic [7:0] IDX_DEV_LO  = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_VEND_HI = 8'h23;
    localparam logic [7:0] IDX_VEND_LO = 8'h24;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;

    localparam logic [15:0] DEVICE_ID = 16'h0406;
    localparam logic [15:0] VENDOR_ID = 16'h1934;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       data_port;
        logic [7:0] byte_in;
    } host_op_t;

    // Identification lookup: {hit, value}
    function automatic logic [8:0] id_byte(input logic [7:0] idx, input logic [7:0] rev);
        case (idx)
            IDX_DEV_HI:  id_byte = {1'b1, DEVICE_ID[15:8]};
            IDX_DEV_LO:  id_byte = {1'b1, DEVICE_ID[7:0]};
            IDX_REV:     id_byte = {1'b1, rev};
            IDX_VEND_HI: id_byte = {1'b1, VENDOR_ID[15:8]};
            IDX_VEND_LO: id_byte = {1'b1, VENDOR_ID[7:0]};
            default:     id_byte = 9'h000;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    lock_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LK_SHUT;
        end else if (idx_wr) begin
            case (st_q)
                LK_SHUT: if (wdata == KEY_ENTER) st_q <= LK_HALF;
                LK_HALF: st_q <= (wdata == KEY_ENTER) ? LK_OPEN : LK_SHUT;
                LK_OPEN: if (wdata == KEY_EXIT) st_q <= LK_SHUT;
                default: st_q <= LK_SHUT;
            endcase
        end
    end

    assign unlocked = (st_q == LK_OPEN);

    AST_KEY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_HALF && idx_wr && wdata != KEY_ENTER) |=> !unlocked) // R3
        else $error("broken key sequence unlocked");

    AST_KEY_EXIT: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && wdata == KEY_EXIT) |=> !unlocked) // R4
        else $error("exit byte did not lock");

    AST_KEY_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_HALF && idx_wr && wdata == KEY_ENTER) |=> unlocked) // R2
        else $error("double key did not unlock");

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_LDEV = 8,
    parameter int HWM_LDEV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        data_wr,
    input  logic [7:0]  idx,
    input  logic [7:0]  ldsel,
    input  logic [7:0]  wdata,
    output logic        sel_act,
    output logic [15:0] sel_base,
    output logic        hwm_active,
    output logic [15:0] hwm_base
);

    localparam int LDW = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

    logic [NUM_LDEV-1:0] act_q;
    logic [15:0]         base_q [NUM_LDEV];
    logic                sel_valid;

    assign sel_valid = (ldsel < 8'(NUM_LDEV));

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_ldev
        logic hit;
        assign hit = data_wr && (ldsel == 8'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[g]  <= 1'b0;
                base_q[g] <= 16'h0000;
            end else if (hit) begin
                if (idx == IDX_ACT)     act_q[g]        <= wdata[0];
                if (idx == IDX_BASE_HI) base_q[g][15:8] <= wdata;
                if (idx == IDX_BASE_LO) base_q[g][7:0]  <= wdata;
            end
        end
    end

    always_comb begin
        sel_act  = 1'b0;
        sel_base = 16'h0000;
        if (sel_valid) begin
            sel_act  = act_q[ldsel[LDW-1:0]];
            sel_base = base_q[ldsel[LDW-1:0]];
        end
    end

    assign hwm_active = act_q[HWM_LDEV];
    assign hwm_base   = base_q[HWM_LDEV];

    AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ldsel != 8'(HWM_LDEV)) |=> ($stable(hwm_base) && $stable(hwm_active))) // R7
        else $error("write to other device changed monitor outputs");

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int         NUM_LDEV = 8,
    parameter int         HWM_LDEV = 4,
    parameter logic [7:0] DEV_REV  = 8'h11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        port_sel,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        hwm_active,
    output logic [15:0] hwm_base
);

    host_op_t   op;
    logic       unlocked;
    logic [7:0] idx_q;
    logic [7:0] ldsel_q;
    logic [7:0] rdata_q;
    logic [7:0] rd_val;
    logic       sel_act;
    logic [15:0] sel_base;
    logic [8:0] id_hit;
    logic       data_wr;

    assign op = '{wr: wr_en, rd: rd_en, data_port: port_sel, byte_in: wdata};

    sio_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (op.wr && !op.data_port),
        .wdata    (op.byte_in),
        .unlocked (unlocked)
    );

    assign data_wr = op.wr && op.data_port && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= 8'h00;
            ldsel_q <= 8'h00;
        end else begin
            if (op.wr && !op.data_port && unlocked && op.byte_in != KEY_EXIT)
                idx_q <= op.byte_in;
            if (data_wr && idx_q == IDX_LDSEL)
                ldsel_q <= op.byte_in;
        end
    end

    sio_ldev_bank #(
        .NUM_LDEV (NUM_LDEV),
        .HWM_LDEV (HWM_LDEV)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (data_wr),
        .idx        (idx_q),
        .ldsel      (ldsel_q),
        .wdata      (op.byte_in),
        .sel_act    (sel_act),
        .sel_base   (sel_base),
        .hwm_active (hwm_active),
        .hwm_base   (hwm_base)
    );

    assign id_hit = id_byte(idx_q, DEV_REV);

    always_comb begin
        if (!unlocked) begin
            rd_val = LOCKED_READ;
        end else if (!op.data_port) begin
            rd_val = idx_q;
        end else begin
            case (idx_q)
                IDX_LDSEL:   rd_val = ldsel_q;
                IDX_ACT:     rd_val = {7'b0, sel_act};
                IDX_BASE_HI: rd_val = sel_base[15:8];
                IDX_BASE_LO: rd_val = sel_base[7:0];
                default:     rd_val = id_hit[8] ? id_hit[7:0] : 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= 8'h00;
        else if (op.rd) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;

    AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !unlocked) |=> (rdata == LOCKED_READ)) // R5
        else $error("locked read not 0xFF");

    AST_LOCKED_NOWRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel && !unlocked) |=> ($stable(hwm_base) && $stable(hwm_active))) // R5
        else $error("locked write changed state");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)) // R10
        else $error("rdata moved without read");

    AST_VENDOR_HI: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_sel && unlocked && idx_q == IDX_VEND_HI) |=> (rdata == 8'h19)) // R6
        else $error("vendor id high byte wrong");

endmodule

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        hwm_active;
    logic [15:0] hwm_base;

    always #2 clk = ~clk;

    sio_cfg_port u_sio_cfg_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata), .hwm_active(hwm_active), .hwm_base(hwm_base)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // behavioural reference model
    int         m_lock = 0;     // 0 shut, 1 one key seen, 2 open
    int         m_idx = 0;
    int         m_sel = 0;
    bit         m_act [8];
    int         m_base [8];
    int         m_rdata = 0;

    function automatic int model_read(bit dport);
        if (m_lock != 2) return 255;
        if (!dport) return m_idx;
        case (m_idx)
            7:    return m_sel;
            'h20: return 'h04;
            'h21: return 'h06;
            'h22: return 'h11;
            'h23: return 'h19;
            'h24: return 'h34;
            'h30: return (m_sel < 8) ? int'(m_act[m_sel]) : 0;
            'h60: return (m_sel < 8) ? (m_base[m_sel] >> 8) : 0;
            'h61: return (m_sel < 8) ? (m_base[m_sel] & 255) : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lock = 0; m_idx = 0; m_sel = 0; m_rdata = 0;
            for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_base[i] = 0; end
        end else begin
            if (rd_en) m_rdata = model_read(port_sel);
            if (wr_en && !port_sel) begin
                if (m_lock == 2) begin
                    if (wdata == 8'hAA) m_lock = 0; else m_idx = wdata;
                end else if (m_lock == 1) begin
                    m_lock = (wdata == 8'h87) ? 2 : 0;
                end else if (wdata == 8'h87) begin
                    m_lock = 1;
                end
            end else if (wr_en && port_sel && m_lock == 2) begin
                if (m_idx == 7) m_sel = wdata;
                else if (m_sel < 8) begin
                    if (m_idx == 'h30) m_act[m_sel] = wdata[0];
                    if (m_idx == 'h60) m_base[m_sel] = (m_base[m_sel] & 255) | (int'(wdata) << 8);
                    if (m_idx == 'h61) m_base[m_sel] = (m_base[m_sel] & 'hFF00) | int'(wdata);
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one host cycle: compare model at the falling edge, then drive
    task automatic drive(bit w, bit r, bit s, logic [7:0] d);
        @(negedge clk);
        if (!rst) begin
            check({cur_req, " rdata"}, int'(rdata), m_rdata);
            check({cur_req, " hwm_active"}, int'(hwm_active), int'(m_act[4]));
            check({cur_req, " hwm_base"}, int'(hwm_base), m_base[4]);
        end
        wr_en = w; rd_en = r; port_sel = s; wdata = d;
    endtask

    task automatic idle(); drive(0, 0, 0, 8'h00); endtask
    task automatic wr_idx(logic [7:0] d); drive(1, 0, 0, d); endtask
    task automatic wr_dat(logic [7:0] d); drive(1, 0, 1, d); endtask
    task automatic rd_port(bit s, int exp, string req);
        drive(0, 1, s, 8'h00);
        idle();
        check(req, int'(rdata), exp);
    endtask
    task automatic unlock(); wr_idx(8'h87); wr_idx(8'h87); endtask
    task automatic set_reg(logic [7:0] i, logic [7:0] d); wr_idx(i); wr_dat(d); endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        idle();
        check("R1 reset rdata", int'(rdata), 0);
        check("R1 reset active", int'(hwm_active), 0);
        check("R1 reset base", int'(hwm_base), 0);

        cur_req = "R5";
        rd_port(1, 'hFF, "R5 locked data read");
        rd_port(0, 'hFF, "R5 locked index read");

        // R3: broken key sequence
        cur_req = "R3";
        wr_idx(8'h87); wr_idx(8'h12); wr_idx(8'h87);
        rd_port(1, 'hFF, "R3 single key stays locked");
        cur_req = "R2";
        wr_idx(8'h87);
        rd_port(0, 'h00, "R2 unlocked index read");

        cur_req = "R6";
        set_reg(8'h20, 8'h55);
        rd_port(1, 'h04, "R6 device id high");
        wr_idx(8'h21); rd_port(1, 'h06, "R6 device id low");
        wr_idx(8'h22); rd_port(1, 'h11, "R6 revision");
        wr_idx(8'h23); rd_port(1, 'h19, "R6 vendor high");
        wr_idx(8'h24); rd_port(1, 'h34, "R6 vendor low");

        cur_req = "R9";
        wr_idx(8'h45); rd_port(1, 'h00, "R9 unimplemented index");

        cur_req = "R8";
        set_reg(8'h07, 8'h04);
        set_reg(8'h30, 8'hFF);
        idle();
        check("R8 activate out", int'(hwm_active), 1);
        rd_port(1, 'h01, "R9 activate upper bits zero");
        set_reg(8'h60, 8'h0A);
        set_reg(8'h61, 8'h2E);
        idle();
        check("R8 base out", int'(hwm_base), 'h0A2E);

        cur_req = "R7";
        set_reg(8'h07, 8'h02);
        set_reg(8'h60, 8'h12);
        set_reg(8'h30, 8'h00);
        idle();
        check("R7 other device isolated base", int'(hwm_base), 'h0A2E);
        check("R7 other device isolated act", int'(hwm_active), 1);
        wr_idx(8'h60); rd_port(1, 'h12, "R7 banked base of device 2");
        set_reg(8'h07, 8'h04);
        wr_idx(8'h61); rd_port(1, 'h2E, "R7 banked base of device 4");
        set_reg(8'h07, 8'h20);
        set_reg(8'h30, 8'h01);
        rd_port(1, 'h00, "R7 out of range selector");
        wr_idx(8'h07); rd_port(1, 'h20, "R7 selector readback");

        cur_req = "R11";
        wr_idx(8'h61);
        rd_port(0, 'h61, "R11 index readback");

        cur_req = "R10";
        rd_port(0, 'h61, "R10 read latency");
        wr_idx(8'h30);
        idle(); idle(); idle();
        check("R10 rdata holds", int'(rdata), 'h61);

        cur_req = "R4";
        wr_idx(8'hAA);
        rd_port(1, 'hFF, "R4 exit locks");

        cur_req = "R5";
        wr_dat(8'h00);
        unlock();
        set_reg(8'h07, 8'h04);
        wr_idx(8'h60);
        wr_idx(8'hAA);
        wr_dat(8'h77);
        wr_idx(8'h5A);
        idle();
        check("R5 locked write ignored", int'(hwm_base), 'h0A2E);
        unlock();
        rd_port(0, 'h60, "R5 locked index write ignored");
        rd_port(1, 'h0A, "R5 base unchanged after locked write");

        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule